// File: doc/BRIEF.md
# Saturating Integer/Float Converter

This unit converts 32-bit words for a floating-point coprocessor, in either direction. In one direction a signed two's-complement integer becomes an IEEE-754 single-precision value, rounded to nearest with ties to even. In the other direction a single-precision value becomes a signed 32-bit integer, truncated toward zero.

Overflow on the float-to-integer path is found from the exponent field alone, with a fixed limit. An operand past that limit does not raise an exception. It returns a fixed code chosen by its sign bit.

The operand and an opcode bit arrive on a valid/ready input. The input is always ready, so a new operand can go in on every cycle. Each result appears two cycles later, marked by a single-cycle valid strobe.

Top module: `fcvt_sat`

## Requirements
- R1: With `in_op`=1 (float to integer) and an exponent field (bits 30:23) from 1 to 157, the result is the operand's value truncated toward zero, as a two's-complement 32-bit integer; a magnitude below 1.0 gives 0.
- R2: With `in_op`=1, an exponent field above 157 and bit 31 set (this includes -infinity and NaNs), the result is 0x80000000.
- R3: With `in_op`=1, an exponent field above 157 and bit 31 clear, the result is 0x7FFFFFFF.
- R4: With `in_op`=1 and an exponent field of 0, the operand counts as zero and the result is 0, whatever the fraction and sign bits hold.
- R5: With `in_op`=0 (integer to float), an integer whose magnitude is below 2^24 converts exactly to sign, biased exponent and fraction.
- R6: With `in_op`=0 and a magnitude that needs more than 24 significant bits, the fraction is rounded to the nearest value, and a tie goes to the even fraction. A carry out of the fraction raises the exponent.
- R7: With `in_op`=0, an input of 0 gives 0x00000000 and an input of 0x80000000 gives 0xCF000000.
- R8: `in_ready` is always 1. An operand accepted at clock edge k gives `out_valid`=1 with its result after edge k+2. Operands accepted on back-to-back cycles come out on back-to-back cycles, in order. `out_valid` is 0 in every cycle that has no such result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken (always 1) |
| in_op | input | 1 | 0: integer to float, 1: float to integer |
| in_data | input | 32 | Operand |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | Result |

## Verification
Integer-to-float is tried with small signed values, which separate sign and exponent handling from rounding. Values just past 2^24 land on ties with odd and with even fractions, and a non-tie value, so they separate round-half-even from truncation and from round-half-up. 0x7FFFFFFF exercises the exponent carry, and 0x80000000 the negation corner.

Float-to-integer is tried with fractions of each sign, with random operands whose exponents run up to the limit, and with values exactly at 157 and at 158. It is also tried with infinities and denormals. These cases separate truncation from rounding, an off-by-one limit from the correct one, and the two saturation codes from each other.

Back-to-back and gapped issue patterns check the fixed latency and the result order.

// File: rtl/fcvt_sat.sv
module fcvt_sat #(
  parameter int W         = 32,
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int BIAS      = 127,
  parameter int SAT_LIMIT = 157
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_op,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int MANT_W = FRAC_W + 1;
  localparam int POINT  = BIAS + FRAC_W;
  localparam int LOG_W  = $clog2(W);

  logic         v1, op1;
  logic [W-1:0] d1;

  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1  <= 1'b0;
      op1 <= 1'b0;
      d1  <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        op1 <= in_op;
        d1  <= in_data;
      end
    end
  end

  // integer to float
  logic             i_neg;
  logic [W-1:0]     i_mag, i_norm;
  logic [LOG_W-1:0] i_msb;
  logic [EXP_W-1:0] i_exp;
  logic             i_guard, i_sticky, i_up;
  logic [W-2:0]     i_body;
  logic [W-1:0]     i_res;

  assign i_neg = d1[W-1];
  assign i_mag = i_neg ? (~d1 + 1'b1) : d1;

  always_comb begin
    i_msb = '0;
    for (int i = 0; i < W; i++)
      if (i_mag[i]) i_msb = LOG_W'(i);
  end

  assign i_norm   = i_mag << (LOG_W'(W - 1) - i_msb);
  assign i_exp    = EXP_W'(BIAS) + EXP_W'(i_msb);
  assign i_guard  = i_norm[W-2-FRAC_W];
  assign i_sticky = |i_norm[W-3-FRAC_W:0];
  assign i_up     = i_guard & (i_sticky | i_norm[W-1-FRAC_W]);
  assign i_body   = {i_exp, i_norm[W-2 -: FRAC_W]} + (W-1)'(i_up);
  assign i_res    = (i_mag == '0) ? '0 : {i_neg, i_body};

  // float to integer
  logic             f_neg;
  logic [EXP_W-1:0] f_exp;
  logic [W-1:0]     f_mant, f_mag, f_res;

  assign f_neg  = d1[W-1];
  assign f_exp  = d1[W-2 -: EXP_W];
  assign f_mant = W'({1'b1, d1[FRAC_W-1:0]});

  always_comb begin
    if (f_exp < EXP_W'(BIAS))
      f_mag = '0;
    else if (f_exp >= EXP_W'(POINT))
      f_mag = f_mant << (f_exp - EXP_W'(POINT));
    else
      f_mag = f_mant >> (EXP_W'(POINT) - f_exp);
  end

  always_comb begin
    if (f_exp > EXP_W'(SAT_LIMIT))
      f_res = f_neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      f_res = f_neg ? (~f_mag + 1'b1) : f_mag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_data <= op1 ? f_res : i_res;
    end
  end

  a_r8_issue_to_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> !out_valid);
  a_r2_sat_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && op1 && f_exp > EXP_W'(SAT_LIMIT) && d1[W-1]) |=> out_data == {1'b1, {(W-1){1'b0}}});
  a_r3_sat_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && op1 && f_exp > EXP_W'(SAT_LIMIT) && !d1[W-1]) |=> out_data == {1'b0, {(W-1){1'b1}}});
  a_r4_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && op1 && f_exp == '0) |=> out_data == '0);
  a_r7_int_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !op1 && d1 == '0) |=> out_data == '0);
  a_r1_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && op1 && f_exp >= EXP_W'(BIAS) && f_exp <= EXP_W'(SAT_LIMIT)) |=> out_data[W-1] == $past(d1[W-1]));
endmodule

// File: tb/tb_fcvt_sat.sv
module tb_fcvt_sat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_data;

  fcvt_sat dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
                .in_op(in_op), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] q_exp[$];
  int          q_cyc[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at negedge, operand taken at next posedge
  task automatic send(input string tag, input logic op, input logic [31:0] d, input logic [31:0] e);
    in_valid = 1'b1; in_op = op; in_data = d;
    q_exp.push_back(e); q_cyc.push_back(cyc); q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] f2i_model(input logic [31:0] f);
    int e;
    real v;
    e = int'(f[30:23]);
    if (e == 0) return 32'd0;
    if (e > 157) return f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    v = real'(int'({1'b1, f[22:0]})) * (2.0 ** (e - 150));
    if (f[31]) v = -v;
    return $rtoi(v);
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected result actual=%h expected=none", out_data);
      end else begin
        check(q_tag[0], out_data, q_exp[0]);
        check("R8 latency", 32'(cyc), 32'(q_cyc[0] + 2));
        void'(q_exp.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R8 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 / R5 / R6 back-to-back
    send("R7 zero", 1'b0, 32'd0, 32'h0000_0000);
    send("R7 minint", 1'b0, 32'h8000_0000, 32'hCF00_0000);
    send("R5 one", 1'b0, 32'd1, 32'h3F80_0000);
    send("R5 minus one", 1'b0, 32'hFFFF_FFFF, 32'hBF80_0000);
    send("R5 hundred", 1'b0, 32'd100, 32'h42C8_0000);
    send("R5 minus hundred", 1'b0, -32'sd100, 32'hC2C8_0000);
    send("R5 million", 1'b0, 32'd1000000, 32'h4974_2400);
    send("R5 two", 1'b0, 32'd2, 32'h4000_0000);
    send("R6 tie even down", 1'b0, 32'h0100_0001, 32'h4B80_0000);
    send("R6 tie odd up", 1'b0, 32'h0100_0003, 32'h4B80_0002);
    send("R6 tie even keep", 1'b0, 32'h0100_0005, 32'h4B80_0002);
    send("R6 nearest up", 1'b0, 32'h0200_0003, 32'h4C00_0001);
    send("R6 carry maxint", 1'b0, 32'h7FFF_FFFF, 32'h4F00_0000);
    // float to int, gapped
    send("R1 one", 1'b1, 32'h3F80_0000, 32'd1);
    @(negedge clk);
    send("R1 minus 1.5", 1'b1, 32'hBFC0_0000, 32'hFFFF_FFFF);
    send("R1 half", 1'b1, 32'h3F00_0000, 32'd0);
    send("R1 minus 123.5", 1'b1, 32'hC2F7_0000, -32'sd123);
    send("R1 limit pos", 1'b1, 32'h4EFF_FFFF, 32'h7FFF_FF80);
    send("R1 limit neg", 1'b1, 32'hCEFF_FFFF, 32'h8000_0080);
    @(negedge clk); @(negedge clk);
    send("R3 2^31", 1'b1, 32'h4F00_0000, 32'h7FFF_FFFF);
    send("R2 -2^31", 1'b1, 32'hCF00_0000, 32'h8000_0000);
    send("R3 +inf", 1'b1, 32'h7F80_0000, 32'h7FFF_FFFF);
    send("R2 -inf", 1'b1, 32'hFF80_0000, 32'h8000_0000);
    send("R2 neg nan", 1'b1, 32'hFFC0_0001, 32'h8000_0000);
    send("R4 denormal", 1'b1, 32'h0040_0000, 32'd0);
    send("R4 neg denormal", 1'b1, 32'h807F_FFFF, 32'd0);
    for (int i = 0; i < 200; i++) begin
      logic [31:0] f;
      f = $urandom;
      f[30:23] = 8'(100 + ($urandom % 70));
      send("R1 random", 1'b1, f, f2i_model(f));
      if (i % 7 == 0) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check("R8 queue drained", 32'(q_exp.size()), 32'd0);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end
endmodule